// File: doc/BRIEF.md
# Infrared Edge-Interval Meter

This block times the gaps between transitions of a demodulated infrared receiver output. The raw line is first brought into the system clock domain. A spike filter then drops any level that does not persist for a selectable number of clocks. A free-running prescaler produces a slow timebase tick at nominally 12.5 kHz, so one count is 80 µs. An 8-bit counter counts those ticks since the last qualifying edge. On each qualifying edge, or when the counter saturates, the count is captured into a read-only pulse register and an interrupt flag is raised.

Software selects which edge polarities qualify and which filter width applies, and it acknowledges each interrupt by writing to the pulse register. If no edge arrives for 255 ticks (about 20 ms), the counter saturates. The value 255 is then captured and a hidden overflow state is entered. In that state the captured value is frozen and no new request is raised until the acknowledging write. A routing bit hands the shared interrupt output over to an external pin instead.

Top module: `ir_interval_meter`

## Requirements
- R1: After reset the control register reads 00h, the pulse register reads 00h and irq_o is 0.
- R2: A level change on ir_raw_i (after a two-flop synchronizer) reaches the edge detector only once it has held for FILT_SHORT consecutive clocks when control bit 3 is 0, or for FILT_LONG consecutive clocks when bit 3 is 1. A shorter pulse has no effect on the pulse register or irq_o.
- R3: Control bit 2 makes rising edges qualify and control bit 1 makes falling edges qualify, so both set means either edge qualifies. With both clear, no edge captures and a capture happens only at saturation.
- R4: On a qualifying edge with overflow clear, the pulse register takes the number of ticks counted since the previous qualifying edge, the counter restarts at 0 and the interrupt flag is set. A value not yet acknowledged is overwritten.
- R5: The tick counter stops at 255 and holds there until the next qualifying edge.
- R6: When the counter steps from 254 to 255 with overflow clear, the pulse register becomes 255 in that same cycle, and both the interrupt flag and the overflow state are set.
- R7: While the overflow state is set, the pulse register does not change and no new request is produced.
- R8: A write to address 1 (the pulse register) clears the interrupt flag and the overflow state. A capture in the same cycle, with overflow clear, still sets the flag.
- R9: A write to address 0 stores data bits 4:1 into the control register. Reading address 0 returns those bits, with bits 7:5 and bit 0 reading 0.
- R10: When control bit 4 is 0, irq_o carries the interrupt flag. When it is 1, irq_o follows ext_irq_pin_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ir_raw_i | input | 1 | Demodulated infrared receiver output |
| ext_irq_pin_i | input | 1 | External interrupt pin sharing the request output |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 control, 1 pulse |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the selected register |
| irq_o | output | 1 | Interrupt request output |

## Verification
Square pulse trains of several widths run in each of the four edge-selection settings. Because captured counts differ with polarity, these trains separate rising-only, falling-only, either-edge and saturation-only behaviour. Glitches one clock shorter than each filter width, and exactly at it, show that the threshold sits on the right clock and follows the width bit. Long idle stretches drive the counter into saturation, and edges sent while overflow is pending show whether the capture stays frozen until the acknowledge. Back-to-back edges without an acknowledge show that newer counts overwrite older ones.

// File: rtl/ir_meter_pkg.sv
package ir_meter_pkg;
  localparam int unsigned CNT_W      = 8;
  localparam logic        ADDR_CTRL  = 1'b0;
  localparam logic        ADDR_PULSE = 1'b1;

  typedef struct packed {
    logic route_ext;  // bit 4
    logic wide_filt;  // bit 3
    logic rise_en;    // bit 2
    logic fall_en;    // bit 1
  } ctrl_t;
endpackage

// File: rtl/ir_glitch_filter.sv
module ir_glitch_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_SHORT  = 100,
  parameter int unsigned FILT_LONG   = 8000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  input  logic wide_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned FC_W = $clog2(FILT_LONG + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   level_q;
  logic [FC_W-1:0]        run_q;
  logic [FC_W-1:0]        limit;
  logic                   settled;

  assign settled = sync_q[SYNC_STAGES-1];
  assign limit   = wide_i ? FC_W'(FILT_LONG - 1) : FC_W'(FILT_SHORT - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
  end

  // level only moves after settled has differed for limit+1 clocks
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= 1'b0;
      run_q   <= '0;
      rise_o  <= 1'b0;
      fall_o  <= 1'b0;
    end else begin
      rise_o <= 1'b0;
      fall_o <= 1'b0;
      if (settled != level_q) begin
        if (run_q >= limit) begin
          level_q <= settled;
          run_q   <= '0;
          rise_o  <= settled;
          fall_o  <= ~settled;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else begin
        run_q <= '0;
      end
    end
  end
endmodule

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
  parameter int unsigned CLK_PER_TICK = 4000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned PC_W = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
  localparam logic [PC_W-1:0] LAST = PC_W'(CLK_PER_TICK - 1);

  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      tick_o <= 1'b0;
    end else begin
      pc_q   <= (pc_q == LAST) ? '0 : pc_q + 1'b1;
      tick_o <= (pc_q == LAST);
    end
  end
endmodule

// File: rtl/ir_interval_core.sv
module ir_interval_core
  import ir_meter_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             rise_en_i,
  input  logic             fall_en_i,
  input  logic             ack_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] pulse_o,
  output logic             irq_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] MAX = '1;

  logic qual;
  logic sat_hit;

  assign qual    = (rise_i & rise_en_i) | (fall_i & fall_en_i);
  assign sat_hit = tick_i & ~qual & (cnt_o == MAX - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o   <= '0;
      pulse_o <= '0;
      irq_o   <= 1'b0;
      ovf_o   <= 1'b0;
    end else begin
      if (qual)                      cnt_o <= '0;
      else if (tick_i && cnt_o != MAX) cnt_o <= cnt_o + 1'b1;

      if (ack_i) begin
        irq_o <= 1'b0;
        ovf_o <= 1'b0;
      end
      // capture beats a same-cycle acknowledge
      if (!ovf_o) begin
        if (qual) begin
          pulse_o <= cnt_o;
          irq_o   <= 1'b1;
        end else if (sat_hit) begin
          pulse_o <= MAX;
          irq_o   <= 1'b1;
          ovf_o   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ir_interval_meter.sv
module ir_interval_meter
  import ir_meter_pkg::*;
#(
  parameter int unsigned CLK_PER_TICK = 4000,
  parameter int unsigned FILT_SHORT   = 100,
  parameter int unsigned FILT_LONG    = 8000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ir_raw_i,
  input  logic       ext_irq_pin_i,
  input  logic       reg_wr_i,
  input  logic       reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       irq_o
);
  ctrl_t            ctrl_q;
  logic             rise_w, fall_w, tick_w, ack_w;
  logic             irq_flag_w, ovf_w;
  logic [CNT_W-1:0] cnt_w, pulse_w;
  logic             unused_wdata;

  assign unused_wdata = ^{reg_wdata_i[7:5], reg_wdata_i[0]};
  assign ack_w        = reg_wr_i & (reg_addr_i == ADDR_PULSE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 ctrl_q <= '0;
    else if (reg_wr_i && reg_addr_i == ADDR_CTRL) ctrl_q <= ctrl_t'(reg_wdata_i[4:1]);
  end

  ir_glitch_filter #(
    .SYNC_STAGES(2),
    .FILT_SHORT (FILT_SHORT),
    .FILT_LONG  (FILT_LONG)
  ) u_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .raw_i (ir_raw_i),
    .wide_i(ctrl_q.wide_filt),
    .rise_o(rise_w),
    .fall_o(fall_w)
  );

  ir_tick_gen #(.CLK_PER_TICK(CLK_PER_TICK)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick_w)
  );

  ir_interval_core u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_w),
    .rise_i   (rise_w),
    .fall_i   (fall_w),
    .rise_en_i(ctrl_q.rise_en),
    .fall_en_i(ctrl_q.fall_en),
    .ack_i    (ack_w),
    .cnt_o    (cnt_w),
    .pulse_o  (pulse_w),
    .irq_o    (irq_flag_w),
    .ovf_o    (ovf_w)
  );

  assign reg_rdata_o = (reg_addr_i == ADDR_PULSE) ? pulse_w : {3'b000, ctrl_q, 1'b0};
  assign irq_o       = ctrl_q.route_ext ? ext_irq_pin_i : irq_flag_w;
endmodule

// File: rtl/ir_meter_checker.sv
module ir_meter_checker #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ack_i,
  input logic             rise_i,
  input logic             fall_i,
  input logic             tick_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] pulse_i,
  input logic             irq_flag_i,
  input logic             ovf_i
);
  localparam logic [CNT_W-1:0] MAX = '1;

  assert_cnt_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == MAX && !rise_i && !fall_i) |=> (cnt_i == MAX));

  assert_ovf_capture_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_i) |-> (pulse_i == MAX && irq_flag_i));

  assert_frozen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_i && !ack_i) |=> $stable(pulse_i));

  assert_ovf_needs_irq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |-> irq_flag_i);

  assert_ack_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !rise_i && !fall_i && !tick_i) |=> (!irq_flag_i && !ovf_i));
endmodule

bind ir_interval_meter ir_meter_checker #(.CNT_W(ir_meter_pkg::CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ack_i     (ack_w),
  .rise_i    (rise_w),
  .fall_i    (fall_w),
  .tick_i    (tick_w),
  .cnt_i     (cnt_w),
  .pulse_i   (pulse_w),
  .irq_flag_i(irq_flag_w),
  .ovf_i     (ovf_w)
);

// File: tb/sim_ir_interval_meter.sv
`timescale 1ns/1ps
module sim_ir_interval_meter;
  localparam int P  = 8;
  localparam int FS = 4;
  localparam int FL = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ir = 1'b0;
  logic       ext = 1'b0;
  logic       wr = 1'b0;
  logic       addr = 1'b1;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ir_interval_meter #(.CLK_PER_TICK(P), .FILT_SHORT(FS), .FILT_LONG(FL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ir_raw_i(ir), .ext_irq_pin_i(ext),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference, updated at each rising edge
  int m_s1, m_s2, m_lvl, m_run, m_rise, m_fall, m_pc, m_tick;
  int m_cnt, m_pulse, m_irq, m_ovf, m_ctrl;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_lvl = 0; m_run = 0; m_rise = 0; m_fall = 0;
      m_pc = 0; m_tick = 0; m_cnt = 0; m_pulse = 0; m_irq = 0; m_ovf = 0; m_ctrl = 0;
    end else begin
      int q, lim, n_rise, n_fall, n_tick, n_cnt, n_pulse, n_irq, n_ovf;
      q = ((m_rise != 0) && m_ctrl[2]) || ((m_fall != 0) && m_ctrl[1]);
      n_cnt = q ? 0 : ((m_tick != 0 && m_cnt < 255) ? m_cnt + 1 : m_cnt);
      n_pulse = m_pulse; n_irq = m_irq; n_ovf = m_ovf;
      if (wr && addr) begin n_irq = 0; n_ovf = 0; end
      if (m_ovf == 0) begin
        if (q) begin n_pulse = m_cnt; n_irq = 1; end
        else if (m_tick != 0 && m_cnt == 254) begin n_pulse = 255; n_irq = 1; n_ovf = 1; end
      end
      lim = m_ctrl[3] ? FL : FS;
      n_rise = 0; n_fall = 0;
      if (m_s2 != m_lvl) begin
        if (m_run + 1 >= lim) begin
          n_rise = m_s2; n_fall = 1 - m_s2; m_lvl = m_s2; m_run = 0;
        end else m_run = m_run + 1;
      end else m_run = 0;
      n_tick = (m_pc == P - 1);
      m_pc = (m_pc == P - 1) ? 0 : m_pc + 1;
      if (wr && !addr) m_ctrl = int'(wdata & 8'h1E);
      m_s2 = m_s1; m_s1 = int'(ir);
      m_rise = n_rise; m_fall = n_fall; m_tick = n_tick;
      m_cnt = n_cnt; m_pulse = n_pulse; m_irq = n_irq; m_ovf = n_ovf;
    end
  end

  // every-clock comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int er, ei;
      er = addr ? m_pulse : m_ctrl;
      ei = m_ctrl[4] ? int'(ext) : m_irq;
      total++;
      if (int'(rdata) != er) begin
        bad++;
        $display("FAIL R4 R7 R9 readback at cycle %0d: got %0d exp %0d", cycles, rdata, er);
      end
      total++;
      if (int'(irq) != ei) begin
        bad++;
        $display("FAIL R10 R8 irq at cycle %0d: got %0d exp %0d", cycles, irq, ei);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input int got, input int exp, input string tag);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d exp %0d", tag, got, exp);
    end
  endtask

  task automatic wr_reg(input logic a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; addr = 1'b1;
  endtask

  task automatic hold_ir(input logic v, input int n);
    @(negedge clk);
    ir = v;
    step(n - 1);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk(int'(rdata), 0, "R1 pulse reset");
    chk(int'(irq), 0, "R1 irq reset");
    addr = 1'b0; step(1);
    chk(int'(rdata), 0, "R1 ctrl reset");
    addr = 1'b1;

    // R9 control read-back masks
    wr_reg(1'b0, 8'hFF);
    addr = 1'b0; step(1);
    chk(int'(rdata), 8'h1E, "R9 ctrl readback");
    addr = 1'b1;

    // R10 routed to external pin
    ext = 1'b1; step(2);
    chk(int'(irq), 1, "R10 ext high");
    ext = 1'b0; step(2);
    chk(int'(irq), 0, "R10 ext low");

    // both edges, short filter, train without acknowledge (R3 R4)
    wr_reg(1'b0, 8'h06);
    wr_reg(1'b1, 8'h00);
    hold_ir(1'b1, 40); hold_ir(1'b0, 70); hold_ir(1'b1, 25); hold_ir(1'b0, 90);
    step(10);
    chk(int'(irq), 1, "R4 irq after train");
    chk(int'(rdata) > 0 && int'(rdata) < 20 ? 1 : 0, 1, "R4 small count latched");

    // R2 short-filter glitch threshold
    wr_reg(1'b1, 8'h00);
    step(5);
    hold_ir(1'b1, FS - 1); hold_ir(1'b0, 30);
    chk(int'(irq), 0, "R2 short glitch rejected");
    hold_ir(1'b1, FS); hold_ir(1'b0, 30);
    chk(int'(irq), 1, "R2 short width passes");

    // R2 wide filter
    wr_reg(1'b0, 8'h0E);
    wr_reg(1'b1, 8'h00);
    step(30);
    hold_ir(1'b1, FL - 1); hold_ir(1'b0, 40);
    chk(int'(irq), 0, "R2 wide glitch rejected");
    hold_ir(1'b1, FL); hold_ir(1'b0, 40);
    chk(int'(irq), 1, "R2 wide width passes");

    // R3 rising only
    wr_reg(1'b0, 8'h04);
    wr_reg(1'b1, 8'h00);
    hold_ir(1'b1, 60); hold_ir(1'b0, 35); hold_ir(1'b1, 50); hold_ir(1'b0, 20);
    step(10);
    chk(int'(irq), 1, "R3 rising capture");

    // R3 falling only
    wr_reg(1'b0, 8'h02);
    wr_reg(1'b1, 8'h00);
    hold_ir(1'b1, 45); hold_ir(1'b0, 80); hold_ir(1'b1, 30); hold_ir(1'b0, 20);
    step(10);
    chk(int'(irq), 1, "R3 falling capture");

    // R3 neither: edges alone do not capture
    wr_reg(1'b0, 8'h06);
    hold_ir(1'b1, 20);
    step(10);
    wr_reg(1'b0, 8'h00);
    wr_reg(1'b1, 8'h00);
    hold_ir(1'b0, 30); hold_ir(1'b1, 30); hold_ir(1'b0, 30);
    chk(int'(irq), 0, "R3 no capture with both clear");

    // R5 R6 saturation
    step(256 * P + 40);
    chk(int'(rdata), 255, "R6 saturated value");
    chk(int'(irq), 1, "R6 irq at saturation");

    // R7 frozen during overflow
    wr_reg(1'b0, 8'h06);
    hold_ir(1'b1, 30); hold_ir(1'b0, 30); hold_ir(1'b1, 30);
    step(10);
    chk(int'(rdata), 255, "R7 latch frozen");
    chk(int'(irq), 1, "R7 flag still set");

    // R8 acknowledge
    wr_reg(1'b1, 8'h5A);
    step(1);
    chk(int'(irq), 0, "R8 ack clears");
    hold_ir(1'b0, 40);
    step(10);
    chk(int'(irq), 1, "R8 capture after ack");
    chk(int'(rdata) < 255 ? 1 : 0, 1, "R8 fresh count after ack");

    // R5 hold at 255 then edge after ack captures 255
    wr_reg(1'b1, 8'h00);
    step(256 * P + 40);
    wr_reg(1'b1, 8'h00);
    step(3 * P);
    chk(int'(irq), 0, "R5 no repeat while held");
    hold_ir(1'b1, 30);
    step(5);
    chk(int'(rdata), 255, "R5 held count captured");

    step(5);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule